// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block carries out 32-bit multiplication and division, either signed or unsigned, as a multi-cycle job. The result goes into a pair of result registers, HI and LO. A multiply leaves the upper half of the 64-bit product in HI and the lower half in LO. A divide leaves the remainder in HI and the quotient in LO. The two special divide cases never trap and always give fixed values: a zero divisor, and the most negative signed number divided by minus one.

A caller pulses `start` with an operation code and two operands. The unit then raises `busy` while a bit-serial datapath works through one operand bit per clock. Software can also write HI or LO directly from `wr_data`. A read request names HI or LO and returns the value one cycle later. If a read request arrives while an operation is running, the read waits, and `stall` flags the wait, until the new result has been stored.

Top module: `muldiv_unit`

## Requirements
- R1: After a synchronous reset, `busy`, `stall` and `rd_valid` are low, and reads of both HI (`rd_sel`=1) and LO (`rd_sel`=0) return zero.
- R2: Operation code 0 (signed multiply) sign-extends both operands to 64 bits. The product's upper 32 bits go to HI and its lower 32 bits to LO.
- R3: Operation code 1 (unsigned multiply) zero-extends both operands and splits the 64-bit product between HI and LO in the same way as R2.
- R4: Operation code 3 (unsigned divide) puts the quotient in LO and the remainder in HI. With a zero divisor it gives HI = dividend and LO = 0xFFFFFFFF.
- R5: Operation code 2 (signed divide) truncates the quotient toward zero into LO. The remainder goes to HI and carries the sign of the dividend.
- R6: A signed divide by zero gives HI = dividend. LO is 0xFFFFFFFF for a dividend that is zero or positive, and 1 for a negative dividend.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives HI = 0 and LO = 0x80000000.
- R8: A `start` sampled while idle drives `busy` high from the next cycle for exactly 33 cycles. A `start` sampled while busy is ignored and changes neither the result nor the busy length.
- R9: While idle, `wr_hi` or `wr_lo` loads `wr_data` into HI or LO at the clock edge.
- R10: A read request sampled while idle gives `rd_valid` high one cycle later, with the value the register held before any write in that same cycle. A request held during `busy` keeps `stall` high and `rd_valid` low, and returns the new result once the operation has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| wr_hi | input | 1 | Load HI from wr_data |
| wr_lo | input | 1 | Load LO from wr_data |
| wr_data | input | 32 | Data for direct loads |
| rd_req | input | 1 | Read request |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| stall | output | 1 | Read request held back by a running operation |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
Two pairs of events can fall in the same cycle and are both provoked on purpose. The first pair is a read request held through a whole operation: it overlaps the cycle in which the result lands in HI, and the bench judges it correct only if `stall` stays high, no early `rd_valid` appears, and the data returned is the new result rather than the old one. The second pair is a read and a direct load of the same register in one idle cycle: the bench expects the old value, and a later read must then show the new one. A second `start` pulsed during the first busy cycle must leave both the result and the 33-cycle busy window unchanged. Random operands, with zero divisors and the overflow pair mixed in, are checked against reference functions in the bench.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    MD_MUL_S = 2'd0,
    MD_MUL_U = 2'd1,
    MD_DIV_S = 2'd2,
    MD_DIV_U = 2'd3
  } md_op_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic           neg_q;
  logic [W:0]     sum;
  logic [2*W-1:0] prod_n;
  logic [2*W-1:0] res;

  function automatic logic [W-1:0] mag(input logic [W-1:0] x, input logic s);
    return (s && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  assign busy_o = (cnt_q != '0);

  always_comb begin
    sum    = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
    prod_n = {sum, prod_q[W-1:1]};
    res    = neg_q ? (~prod_n + 1'b1) : prod_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      mcand_q <= '0;
      prod_q  <= '0;
      neg_q   <= 1'b0;
      done_o  <= 1'b0;
      hi_o    <= '0;
      lo_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && cnt_q == '0) begin
        mcand_q <= mag(a_i, sgn_i);
        prod_q  <= {{W{1'b0}}, mag(b_i, sgn_i)};
        neg_q   <= sgn_i & (a_i[W-1] ^ b_i[W-1]);
        cnt_q   <= CW'(W);
      end else if (cnt_q != '0) begin
        prod_q <= prod_n;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          done_o <= 1'b1;
          hi_o   <= res[2*W-1:W];
          lo_o   <= res[W-1:0];
        end
      end
    end
  end

  // a zero multiplicand must yield an all-zero product (R2)
  assert_zero_mcand_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(1) && mcand_q == '0) |=> (done_o && hi_o == '0 && lo_o == '0));

  // completion is a single-cycle pulse (R8)
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  dvsr_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic          negq_q;
  logic          negr_q;
  logic          sgn_q;
  logic [W:0]    shifted;
  logic [W:0]    diff;
  logic [W-1:0]  rem_n;
  logic [W-1:0]  quo_n;
  logic [W-1:0]  rem_fix;
  logic [W-1:0]  quo_fix;

  function automatic logic [W-1:0] mag(input logic [W-1:0] x, input logic s);
    return (s && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  assign busy_o = (cnt_q != '0);

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dvsr_q};
    if (!diff[W]) begin
      rem_n = diff[W-1:0];
      quo_n = {quo_q[W-2:0], 1'b1};
    end else begin
      rem_n = shifted[W-1:0];
      quo_n = {quo_q[W-2:0], 1'b0};
    end
    quo_fix = negq_q ? (~quo_n + 1'b1) : quo_n;
    rem_fix = negr_q ? (~rem_n + 1'b1) : rem_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      dvsr_q <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      sgn_q  <= 1'b0;
      done_o <= 1'b0;
      hi_o   <= '0;
      lo_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && cnt_q == '0) begin
        dvsr_q <= mag(b_i, sgn_i);
        quo_q  <= mag(a_i, sgn_i);
        rem_q  <= '0;
        negq_q <= sgn_i & (a_i[W-1] ^ b_i[W-1]);
        negr_q <= sgn_i & a_i[W-1];
        sgn_q  <= sgn_i;
        cnt_q  <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          done_o <= 1'b1;
          hi_o   <= rem_fix;
          lo_o   <= quo_fix;
        end
      end
    end
  end

  // unsigned zero divisor yields an all-ones quotient (R4)
  assert_udiv_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(1) && dvsr_q == '0 && !sgn_q) |=> (lo_o == '1));

  // signed zero divisor: quotient 1 for negative dividend, else all ones (R6)
  assert_sdiv_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(1) && dvsr_q == '0 && sgn_q) |=>
      (lo_o == ($past(negr_q) ? W'(1) : {W{1'b1}})));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic         stall,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  import muldiv_pkg::*;

  md_op_e       op_e;
  logic         busy_q;
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;
  logic         go;
  logic         is_div;
  logic         is_sgn;
  logic         mul_busy, mul_done, div_busy, div_done;
  logic [W-1:0] mul_hi, mul_lo, div_hi, div_lo;

  assign op_e   = md_op_e'(op);
  assign go     = start && !busy_q;
  assign is_div = (op_e == MD_DIV_S) || (op_e == MD_DIV_U);
  assign is_sgn = (op_e == MD_MUL_S) || (op_e == MD_DIV_S);
  assign busy   = busy_q;
  assign stall  = rd_req && busy_q;

  muldiv_mul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .start_i(go && !is_div), .sgn_i(is_sgn),
    .a_i(opa), .b_i(opb), .busy_o(mul_busy), .done_o(mul_done),
    .hi_o(mul_hi), .lo_o(mul_lo)
  );

  muldiv_div #(.W(W)) u_div (
    .clk(clk), .rst(rst), .start_i(go && is_div), .sgn_i(is_sgn),
    .a_i(opa), .b_i(opb), .busy_o(div_busy), .done_o(div_done),
    .hi_o(div_hi), .lo_o(div_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req && !busy_q;
      if (rd_req && !busy_q) rd_data <= rd_sel ? hi_q : lo_q;
      if (busy_q) begin
        if (mul_done) begin
          hi_q   <= mul_hi;
          lo_q   <= mul_lo;
          busy_q <= 1'b0;
        end else if (div_done) begin
          hi_q   <= div_hi;
          lo_q   <= div_lo;
          busy_q <= 1'b0;
        end
      end else begin
        if (wr_hi) hi_q <= wr_data;
        if (wr_lo) lo_q <= wr_data;
        if (start) busy_q <= 1'b1;
      end
    end
  end

  // a read seen while busy never completes in the next cycle (R10)
  assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_req && busy) |=> !rd_valid);

  // busy only rises after an accepted start (R8)
  assert_busy_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start));

  // the datapaths never run concurrently, and the top is busy whenever one runs (R8)
  assert_one_unit_R8: assert property (@(posedge clk) disable iff (rst)
    (mul_busy || div_busy) |-> (busy_q && !(mul_busy && div_busy)));

  // idle direct load reaches LO (R9)
  assert_load_lo_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && wr_lo) |=> (lo_q == $past(wr_data)));
endmodule

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] opa = '0, opb = '0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_req = 1'b0, rd_sel = 1'b0;
  logic        busy, stall, rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  muldiv_unit i_muldiv_unit (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .rd_req(rd_req), .rd_sel(rd_sel), .stall(stall), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_calc(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sp;
    logic signed [31:0] sa, sb;
    sa = a;
    sb = b;
    case (o)
      2'd0: begin
        sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        return sp;
      end
      2'd1: return {32'd0, a} * {32'd0, b};
      2'd2: begin
        if (b == 32'd0) return {a, (a[31] ? 32'd1 : 32'hFFFFFFFF)};
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return {32'd0, 32'h80000000};
        return {32'(sa % sb), 32'(sa / sb)};
      end
      default: begin
        if (b == 32'd0) return {a, 32'hFFFFFFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: begin
        if (b == 32'd0) return "R6";
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return "R7";
        return "R5";
      end
      default: return "R4";
    endcase
  endfunction

  task automatic read_reg(input logic sel, output logic [31:0] val, output logic vld);
    @(negedge clk);
    rd_req = 1'b1;
    rd_sel = sel;
    @(negedge clk);
    rd_req = 1'b0;
    val = rd_data;
    vld = rd_valid;
  endtask

  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input bit poke);
    logic [63:0] exp;
    logic [31:0] v;
    logic vld;
    int n;
    string t;
    exp = ref_calc(o, a, b);
    t = tag_of(o, a, b);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && i == 0) begin
        start = 1'b1; op = ~o; opa = $urandom; opb = $urandom;
      end
      if (!busy) break;
      n++;
    end
    start = 1'b0;
    chk("R8 busy length", 32'(n), 32'd33);
    read_reg(1'b1, v, vld);
    chk({t, " HI"}, v, exp[63:32]);
    read_reg(1'b0, v, vld);
    chk({t, " LO"}, v, exp[31:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic vld;
    logic [63:0] exp;
    int n;
    bit seen_early;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 stall", 32'(stall), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    read_reg(1'b1, v, vld);
    chk("R1 HI", v, 32'd0);
    read_reg(1'b0, v, vld);
    chk("R1 LO", v, 32'd0);

    // R9 direct loads
    @(negedge clk);
    wr_hi = 1'b1; wr_data = 32'h1234ABCD;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 32'h0BADF00D;
    @(negedge clk);
    wr_lo = 1'b0;
    read_reg(1'b1, v, vld);
    chk("R9 HI load", v, 32'h1234ABCD);
    read_reg(1'b0, v, vld);
    chk("R9 LO load", v, 32'h0BADF00D);
    chk("R10 rd_valid idle", 32'(vld), 32'd1);

    // R10 read and load of LO in the same cycle return the old value
    @(negedge clk);
    rd_req = 1'b1; rd_sel = 1'b0; wr_lo = 1'b1; wr_data = 32'h55AA55AA;
    @(negedge clk);
    rd_req = 1'b0; wr_lo = 1'b0;
    chk("R10 same-cycle old value", rd_data, 32'h0BADF00D);
    read_reg(1'b0, v, vld);
    chk("R9 LO after same-cycle load", v, 32'h55AA55AA);

    // directed corner cases
    run_op(2'd0, 32'hFFFFFFFD, 32'd7, 1'b0);
    run_op(2'd0, 32'h80000000, 32'h80000000, 1'b0);
    run_op(2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
    run_op(2'd1, 32'd0, 32'h12345678, 1'b0);
    run_op(2'd3, 32'd100, 32'd7, 1'b0);
    run_op(2'd3, 32'hDEADBEEF, 32'd0, 1'b0);
    run_op(2'd2, 32'hFFFFFFF9, 32'd2, 1'b0);
    run_op(2'd2, 32'd7, 32'hFFFFFFFE, 1'b0);
    run_op(2'd2, 32'd5, 32'd0, 1'b0);
    run_op(2'd2, 32'd0, 32'd0, 1'b0);
    run_op(2'd2, 32'hFFFFFF00, 32'd0, 1'b0);
    run_op(2'd2, 32'h80000000, 32'hFFFFFFFF, 1'b0);
    // R8 start during busy is ignored
    run_op(2'd1, 32'h00010001, 32'h00030005, 1'b1);
    run_op(2'd2, 32'hFFFFF000, 32'd3, 1'b1);

    // R10 read held through an operation
    exp = ref_calc(2'd0, 32'h7FFFFFFF, 32'hFFFFFFFE);
    @(negedge clk);
    start = 1'b1; op = 2'd0; opa = 32'h7FFFFFFF; opb = 32'hFFFFFFFE;
    @(negedge clk);
    start = 1'b0; rd_req = 1'b1; rd_sel = 1'b1;
    seen_early = 1'b0;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rd_valid) break;
      if (busy && !stall) seen_early = 1'b1;
      n++;
    end
    rd_req = 1'b0;
    chk("R10 stall while busy", 32'(seen_early), 32'd0);
    chk("R10 held read valid", 32'(rd_valid), 32'd1);
    chk("R10 held read new HI", rd_data, exp[63:32]);
    chk("R10 wait cycles", 32'(n), 32'd33);

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [1:0] o;
      logic [31:0] a, b;
      int pick;
      o = 2'($urandom);
      a = $urandom;
      b = $urandom;
      pick = int'($urandom % 8);
      if (pick == 0) b = 32'd0;
      else if (pick == 1) begin a = 32'h80000000; b = 32'hFFFFFFFF; end
      else if (pick == 2) b = b >> ($urandom % 32);
      run_op(o, a, b, (pick == 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule